// File: doc/BRIEF.md
# Dual-bank level-0 load/store entry buffer

This block sits between sixteen load/store request ports and the 128-bit path toward a level-1 cache. Each port has its own dedicated 128-bit entry in each of two banks, so the ports write their entries side by side and never share an input multiplexer. Address bit 4 of a request picks the bank that stores it. Each bank holds the operation (read or write), the address, the 128-bit write data and sixteen byte enables per entry.

Each bank drains its held entries through one downstream path. The path carries one transfer per clock, a read or a write, under a valid/ready handshake. A round-robin pointer chooses among the held entries, so no port starves. A write entry is released once the downstream side accepts it. A read entry stays held until the downstream side returns its data, and that data goes straight to the port that asked for it.

A port takes one request at a time. Its ready output stays low while its entry in either bank is held, which also keeps each port's requests in order.

Top module: `l0_buffer_pair`

## Requirements
- R1: After reset every `port_ready` bit is 1, and `dn_valid` and `ret_valid` are all 0.
- R2: A request accepted from port i is stored in the port-i entry of bank b, where b is bit 4 of its address. The other bank's entry for that port is not touched, and bank b's downstream path only ever carries addresses whose bit 4 equals b.
- R3: A request is accepted when `req_valid[i]` and `port_ready[i]` are both 1 at a clock edge. `port_ready[i]` is 0 while port i's entry in either bank is held. A request presented while `port_ready[i]` is 0 is ignored and does not change the stored entry.
- R4: While `dn_valid[b]` is 1, the bank presents one held entry. `dn_write[b]` is 1 for a write and 0 for a read, and the entry's address, write data and byte enables appear unchanged on `dn_addr`, `dn_wdata` and `dn_be`.
- R5: `dn_valid[b]` is 1 exactly when bank b holds at least one entry and has no read waiting for data. The grant goes to the first held entry at or after the round-robin pointer, wrapping from 15 to 0. After a transfer from entry k is accepted, the pointer moves to k+1 (modulo 16).
- R6: While `dn_valid[b]` is 1 and `dn_ready[b]` is 0, the same entry stays presented in the next cycle, even if new entries arrive ahead of it in round-robin order.
- R7: A write entry is released at the edge where it is accepted, so `port_ready` rises in the following cycle.
- R8: After a read is accepted, bank b issues nothing more until `rsp_valid[b]` is 1. In that cycle, `ret_valid[i]` is 1 for the requesting port i, and `ret_data` bits [i*128 +: 128] equal the bank's `rsp_rdata`. The entry is released at that edge.
- R9: `rsp_valid[b]` has no effect while bank b has no read waiting: no `ret_valid` bit rises and no entry is released.
- R10: Reset sets each bank's round-robin pointer to entry 0. If every entry of a bank is held, its first grant after reset is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 16 | Per-port request strobe |
| req_write | input | 16 | Per-port operation, 1 = write, 0 = read |
| req_addr | input | 512 | Per-port address, 32 bits each, port i at [i*32 +: 32] |
| req_wdata | input | 2048 | Per-port write data, 128 bits each |
| req_be | input | 256 | Per-port byte enables, 16 bits each |
| port_ready | output | 16 | Port may present a new request |
| ret_valid | output | 16 | Read data returned to this port this cycle |
| ret_data | output | 2048 | Per-port returned read data, 128 bits each |
| dn_valid | output | 2 | Bank b presents a transfer |
| dn_write | output | 2 | Bank b transfer is a write (1) or a read (0) |
| dn_addr | output | 64 | Bank b address at [b*32 +: 32] |
| dn_wdata | output | 256 | Bank b write data at [b*128 +: 128] |
| dn_be | output | 32 | Bank b byte enables at [b*16 +: 16] |
| dn_ready | input | 2 | Downstream accepts bank b's transfer |
| rsp_valid | input | 2 | Read data for bank b is present |
| rsp_rdata | input | 256 | Bank b read data at [b*128 +: 128] |

## Verification
Every internal error in this block shows at the ports within one or two clocks. A stuck or lost held bit shows the same cycle as a wrong `port_ready`, or as a `dn_valid` with no request behind it. A misplaced round-robin pointer shows at the next grant as the wrong address on `dn_addr`. A lost waiting-for-read flag shows the cycle after the read is accepted, as a new transfer or as data sent to the wrong `ret_valid` bit. The bench keeps a reference model that predicts every output each clock, so it finds the first cycle where the design and the model differ.

// File: rtl/l0_buf_pkg.sv
package l0_buf_pkg;
  localparam int unsigned L0_BANKS = 2;

  // Next round-robin position after idx among n entries.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/l0_rr_pick.sv
module l0_rr_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);
  // The scan runs from the farthest position back to ptr,
  // so the nearest held entry at or after ptr is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (req[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/l0_entry_bank.sv
module l0_entry_bank #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int DW = 128,
  parameter int BW = DW / 8,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cap,
  input  logic [N-1:0]    cap_write,
  input  logic [N*AW-1:0] cap_addr,
  input  logic [N*DW-1:0] cap_wdata,
  input  logic [N*BW-1:0] cap_be,
  output logic [N-1:0]    held,
  output logic            dn_valid,
  output logic            dn_write,
  output logic [AW-1:0]   dn_addr,
  output logic [DW-1:0]   dn_wdata,
  output logic [BW-1:0]   dn_be,
  input  logic            dn_ready,
  input  logic            rsp_valid,
  output logic [N-1:0]    ret_valid,
  output logic            issue_fire,
  output logic            rsp_fire,
  output logic            waiting
);
  import l0_buf_pkg::*;

  logic [N-1:0]  e_held, e_wr;
  logic [AW-1:0] e_addr [N];
  logic [DW-1:0] e_data [N];
  logic [BW-1:0] e_be   [N];

  logic [IW-1:0] rr_ptr, lock_idx, rsp_idx, arb_idx, sel_idx;
  logic          lock_q, wait_q, arb_found;

  l0_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req   (e_held),
    .ptr   (rr_ptr),
    .found (arb_found),
    .idx   (arb_idx)
  );

  assign sel_idx    = lock_q ? lock_idx : arb_idx;
  assign dn_valid   = !wait_q && (lock_q || arb_found);
  assign dn_write   = e_wr[sel_idx];
  assign dn_addr    = e_addr[sel_idx];
  assign dn_wdata   = e_data[sel_idx];
  assign dn_be      = e_be[sel_idx];
  assign issue_fire = dn_valid && dn_ready;
  assign rsp_fire   = wait_q && rsp_valid;
  assign waiting    = wait_q;
  assign held       = e_held;

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic release_i;
    assign release_i = (issue_fire && sel_idx == IW'(i) && e_wr[i])
                    || (rsp_fire && rsp_idx == IW'(i));
    assign ret_valid[i] = rsp_fire && rsp_idx == IW'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_held[i] <= 1'b0;
      end else if (cap[i]) begin
        e_held[i] <= 1'b1;
      end else if (release_i) begin
        e_held[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (cap[i]) begin
        e_wr[i]   <= cap_write[i];
        e_addr[i] <= cap_addr[i*AW +: AW];
        e_data[i] <= cap_wdata[i*DW +: DW];
        e_be[i]   <= cap_be[i*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr   <= '0;
      lock_q   <= 1'b0;
      lock_idx <= '0;
      wait_q   <= 1'b0;
      rsp_idx  <= '0;
    end else begin
      lock_q   <= dn_valid && !dn_ready;
      lock_idx <= sel_idx;
      if (issue_fire) begin
        rr_ptr <= IW'(wrap_next(32'(sel_idx), N));
        if (!e_wr[sel_idx]) begin
          wait_q  <= 1'b1;
          rsp_idx <= sel_idx;
        end
      end else if (rsp_fire) begin
        wait_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/l0_buffer_pair.sv
module l0_buffer_pair #(
  parameter int N        = 16,
  parameter int AW       = 32,
  parameter int DW       = 128,
  parameter int BW       = DW / 8,
  parameter int BANK_BIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_write,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  input  logic [N*BW-1:0] req_be,
  output logic [N-1:0]    port_ready,
  output logic [N-1:0]    ret_valid,
  output logic [N*DW-1:0] ret_data,
  output logic [1:0]      dn_valid,
  output logic [1:0]      dn_write,
  output logic [2*AW-1:0] dn_addr,
  output logic [2*DW-1:0] dn_wdata,
  output logic [2*BW-1:0] dn_be,
  input  logic [1:0]      dn_ready,
  input  logic [1:0]      rsp_valid,
  input  logic [2*DW-1:0] rsp_rdata
);
  logic [N-1:0] bank_sel;
  logic [N-1:0] held_b [2];
  logic [N-1:0] ret_b  [2];
  logic [1:0]   bank_issue, bank_rsp, bank_wait;

  for (genvar i = 0; i < N; i++) begin : g_port
    assign bank_sel[i] = req_addr[i*AW + BANK_BIT];
    assign ret_data[i*DW +: DW] = ret_b[1][i] ? rsp_rdata[DW +: DW] : rsp_rdata[0 +: DW];
  end

  assign port_ready = ~(held_b[0] | held_b[1]);
  assign ret_valid  = ret_b[0] | ret_b[1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [N-1:0] cap_b;
    assign cap_b = req_valid & port_ready & (b == 1 ? bank_sel : ~bank_sel);

    l0_entry_bank #(.N(N), .AW(AW), .DW(DW), .BW(BW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap_b),
      .cap_write  (req_write),
      .cap_addr   (req_addr),
      .cap_wdata  (req_wdata),
      .cap_be     (req_be),
      .held       (held_b[b]),
      .dn_valid   (dn_valid[b]),
      .dn_write   (dn_write[b]),
      .dn_addr    (dn_addr[b*AW +: AW]),
      .dn_wdata   (dn_wdata[b*DW +: DW]),
      .dn_be      (dn_be[b*BW +: BW]),
      .dn_ready   (dn_ready[b]),
      .rsp_valid  (rsp_valid[b]),
      .ret_valid  (ret_b[b]),
      .issue_fire (bank_issue[b]),
      .rsp_fire   (bank_rsp[b]),
      .waiting    (bank_wait[b])
    );
  end
endmodule

// File: rtl/l0_buffer_pair_chk.sv
module l0_buffer_pair_chk #(
  parameter int N        = 16,
  parameter int AW       = 32,
  parameter int BANK_BIT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [N-1:0]    port_ready,
  input logic [N-1:0]    ret_valid,
  input logic [1:0]      dn_valid,
  input logic [1:0]      dn_write,
  input logic [2*AW-1:0] dn_addr,
  input logic [1:0]      dn_ready,
  input logic [1:0]      bank_issue,
  input logic [1:0]      bank_rsp,
  input logic [1:0]      bank_wait
);
  for (genvar i = 0; i < N; i++) begin : g_port
    p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] && port_ready[i] |=> !port_ready[i]);
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    p_bank_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid[b] |-> dn_addr[b*AW + BANK_BIT] == 1'(b));
    p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid[b] && !dn_ready[b] |=> dn_valid[b] && $stable(dn_addr[b*AW +: AW])
                                      && $stable(dn_write[b]));
    p_read_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_issue[b] && !dn_write[b] |=> bank_wait[b]);
    p_quiet_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wait[b] |-> !dn_valid[b]);
  end

  p_ret_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ret_valid) |-> (|bank_rsp));
  p_ret_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ret_valid) <= 2);
endmodule

bind l0_buffer_pair l0_buffer_pair_chk #(.N(N), .AW(AW), .BANK_BIT(BANK_BIT)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .port_ready (port_ready),
  .ret_valid  (ret_valid),
  .dn_valid   (dn_valid),
  .dn_write   (dn_write),
  .dn_addr    (dn_addr),
  .dn_ready   (dn_ready),
  .bank_issue (bank_issue),
  .bank_rsp   (bank_rsp),
  .bank_wait  (bank_wait)
);

// File: tb/test_l0_buffer_pair.sv
module test_l0_buffer_pair;
  localparam int N  = 16;
  localparam int AW = 32;
  localparam int DW = 128;
  localparam int BW = DW / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0, req_write = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N*BW-1:0] req_be = '0;
  logic [N-1:0]    port_ready, ret_valid;
  logic [N*DW-1:0] ret_data;
  logic [1:0]      dn_valid, dn_write;
  logic [2*AW-1:0] dn_addr;
  logic [2*DW-1:0] dn_wdata;
  logic [2*BW-1:0] dn_be;
  logic [1:0]      dn_ready = '0, rsp_valid = '0;
  logic [2*DW-1:0] rsp_rdata = '0;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  l0_buffer_pair i_l0_buffer_pair (.*);

  // Behavioural reference state
  bit            mh [2][N];
  bit            mw [2][N];
  logic [AW-1:0] ma [2][N];
  logic [DW-1:0] md [2][N];
  logic [BW-1:0] mb [2][N];
  int            mptr [2], mridx [2], mlidx [2];
  bit            mwait [2], mlock [2];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic int pick(int b);
    if (mlock[b]) return mlidx[b];
    for (int k = 0; k < N; k++)
      if (mh[b][(mptr[b] + k) % N]) return (mptr[b] + k) % N;
    return -1;
  endfunction

  // Compare all outputs against the model mid-cycle, then advance the model at the edge.
  task automatic cycle();
    int  s [2];
    bit  ev [2];
    bit  rdy [N];
    #1;
    for (int b = 0; b < 2; b++) begin
      s[b]  = pick(b);
      ev[b] = !mwait[b] && s[b] >= 0;
      chk(dn_valid[b] == ev[b], "R5 dn_valid", dn_valid[b], ev[b]);
      if (ev[b]) begin
        chk(dn_write[b] == mw[b][s[b]], "R4 dn_write", dn_write[b], mw[b][s[b]]);
        chk(dn_addr[b*AW +: AW] == ma[b][s[b]], "R2 R4 R5 R6 dn_addr", dn_addr[b*AW +: AW], ma[b][s[b]]);
        chk(dn_wdata[b*DW +: DW] == md[b][s[b]], "R4 dn_wdata", dn_wdata[b*DW +: DW], md[b][s[b]]);
        chk(dn_be[b*BW +: BW] == mb[b][s[b]], "R4 dn_be", dn_be[b*BW +: BW], mb[b][s[b]]);
      end
    end
    for (int i = 0; i < N; i++) begin
      bit rv;
      int rb;
      rdy[i] = !(mh[0][i] || mh[1][i]);
      chk(port_ready[i] == rdy[i], "R3 R7 port_ready", port_ready[i], rdy[i]);
      rv = 0; rb = 0;
      for (int b = 0; b < 2; b++)
        if (mwait[b] && rsp_valid[b] && mridx[b] == i) begin rv = 1; rb = b; end
      chk(ret_valid[i] == rv, "R8 R9 ret_valid", ret_valid[i], rv);
      if (rv) chk(ret_data[i*DW +: DW] == rsp_rdata[rb*DW +: DW], "R8 ret_data",
                  ret_data[i*DW +: DW], rsp_rdata[rb*DW +: DW]);
    end
    @(posedge clk);
    for (int b = 0; b < 2; b++) begin
      if (mwait[b] && rsp_valid[b]) begin
        mh[b][mridx[b]] = 0;
        mwait[b] = 0;
      end
      if (ev[b] && dn_ready[b]) begin
        mptr[b] = (s[b] + 1) % N;
        if (mw[b][s[b]]) mh[b][s[b]] = 0;
        else begin mwait[b] = 1; mridx[b] = s[b]; end
      end
      mlock[b] = ev[b] && !dn_ready[b];
      mlidx[b] = s[b];
    end
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && rdy[i]) begin
        int b;
        b = int'(req_addr[i*AW + 4]);
        mh[b][i] = 1;
        mw[b][i] = req_write[i];
        ma[b][i] = req_addr[i*AW +: AW];
        md[b][i] = req_wdata[i*DW +: DW];
        mb[b][i] = req_be[i*BW +: BW];
      end
    end
    @(negedge clk);
  endtask

  task automatic rand_req(input int pct);
    for (int i = 0; i < N; i++) begin
      req_valid[i] = ($urandom % 100) < pct;
      req_write[i] = $urandom % 2;
      req_addr[i*AW +: AW] = $urandom;
      req_wdata[i*DW +: DW] = {$urandom, $urandom, $urandom, $urandom};
      req_be[i*BW +: BW] = BW'($urandom);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      mptr[b] = 0; mwait[b] = 0; mlock[b] = 0; mridx[b] = 0; mlidx[b] = 0;
      for (int i = 0; i < N; i++) mh[b][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk(port_ready == '1, "R1 port_ready", DW'(port_ready), DW'({N{1'b1}}));
    chk(dn_valid == 2'b00, "R1 dn_valid", DW'(dn_valid), 0);
    chk(ret_valid == '0, "R1 ret_valid", DW'(ret_valid), 0);
    @(negedge clk);

    // R10 R6: every port writes into bank 0 while downstream stalls
    rand_req(100);
    for (int i = 0; i < N; i++) begin
      req_addr[i*AW + 4] = 1'b0;
      req_write[i] = 1'b1;
    end
    cycle();
    req_valid = '0;
    rsp_valid = 2'b11;  // R9: no read is waiting, so this must do nothing
    cycle();
    cycle();
    dn_ready = 2'b11;
    #1;
    chk(dn_addr[0 +: AW] == ma[0][0], "R10 first grant", dn_addr[0 +: AW], ma[0][0]);
    for (int k = 0; k < N + 2; k++) cycle();
    rsp_valid = 2'b00;

    // R8: a single read in bank 1, response delayed
    req_valid = '0;
    req_valid[5] = 1'b1; req_write[5] = 1'b0;
    req_addr[5*AW +: AW] = 32'h0000_1230 | 32'h10;
    cycle();
    req_valid = '0;
    dn_ready = 2'b11;
    cycle();
    cycle();
    cycle();
    rsp_rdata = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    rsp_valid = 2'b10;
    cycle();
    rsp_valid = 2'b00;
    cycle();

    // R2 R3 R4 R5 R7 R8 R9: random traffic with random handshakes
    for (int t = 0; t < 4000; t++) begin
      rand_req(t < 2000 ? 30 : 80);
      dn_ready  = {($urandom % 100) < 70, ($urandom % 100) < 70};
      rsp_valid = {($urandom % 100) < 40, ($urandom % 100) < 40};
      rsp_rdata = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      cycle();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule